// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block sits between a clocked host and an asynchronous 128K x 8 static RAM. The host asks for one word at a time, to read or to write, over a request/ready handshake. For each accepted request the controller runs a fixed, clock-counted sequence on the RAM pins: a 17-bit address, an active-low select and an active-high select, an active-low output enable, a read/write line (high reads, low writes), and a split data bus made of an output word, an input word and a drive enable for the pad.

Every analog minimum (read cycle, address and enable access, output-enable access, write pulse, select-to-end-of-write, data setup, write cycle, write-to-high-impedance) is a parameter in nanoseconds. Each is turned into a cycle count by rounding up against the clock period. The bus turnaround at the start of a write gets one extra cycle of margin. At any time, either the controller or the RAM may drive the data bus, but never both.

Back-pressure rules: `ready` is high only while the controller is idle. A request transfers on a rising edge where `req` and `ready` are both high. `we`, `addr` and `wdata` are sampled only on that edge and may change freely afterwards. `rdata_valid` is a single-cycle pulse with no host stall; the host must take `rdata` in that cycle or later, since `rdata` is held until the next read completes.

Top module: `asram_ctl`

## Requirements
- R1: During and after reset, and whenever `ready` is high, the pins rest idle: `mem_sel_n`=1, `mem_sel`=0, `mem_oe_n`=1, `mem_rw`=1, `mem_dq_oe`=0, and `rdata_valid`=0.
- R2: A request is accepted only on an edge with `req`=1 and `ready`=1. `ready` then stays low until the sequence ends. Changes to `we`, `addr` and `wdata` after acceptance have no effect on the access.
- R3: The two selects always carry opposite levels. The RAM is selected only during the access phases, and the address stays constant while it is selected.
- R4: With the default timing (5 ns clock), a read holds select, `mem_rw`=1 and `mem_oe_n`=0 for 14 cycles. `rdata` is registered at the end of the last of those cycles, and `rdata_valid` is high for exactly one cycle, the 15th after acceptance. `ready` returns in the 16th.
- R5: With the default timing, a write holds `mem_rw`=0 with the RAM selected for 13 cycles. The RAM is then deselected and `mem_rw` raised on the same edge, and `ready` returns in the 15th cycle after acceptance.
- R6: The bus drive enable rises only after `mem_rw` has been low for 6 cycles (write-to-high-impedance time rounded up, plus one).
- R7: `mem_dq_oe` is never high while the RAM may drive the bus: not while it is selected with `mem_rw`=1 and `mem_oe_n`=0, and not for 5 cycles after that condition ends.
- R8: At the end of a write, the low time of `mem_rw` covers the write pulse (10 cycles) and select-to-end-of-write (12 cycles), and `mem_dq_o` has been driven stable for at least 6 cycles (data setup).
- R9: A word written to any address, including address 0 and address 0x1FFFF, is returned by a later read of that address.
- R10: `mem_oe_n` is never low while `mem_rw` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Host request valid |
| we | input | 1 | 1 = write, 0 = read; sampled on acceptance |
| addr | input | 17 | Word address; sampled on acceptance |
| wdata | input | 8 | Write word; sampled on acceptance |
| ready | output | 1 | Controller idle, request can be taken |
| rdata | output | 8 | Last word read |
| rdata_valid | output | 1 | One-cycle pulse when `rdata` is updated |
| mem_addr | output | 17 | RAM address |
| mem_sel_n | output | 1 | RAM select, active low |
| mem_sel | output | 1 | RAM select, active high |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_rw | output | 1 | RAM read/write line, high = read |
| mem_dq_o | output | 8 | Word driven toward the RAM |
| mem_dq_i | input | 8 | Word arriving from the RAM |
| mem_dq_oe | output | 1 | Pad drive enable for `mem_dq_o` |

## Verification
The hardest situation to reach is a bus conflict, where the controller starts driving while the RAM still holds the bus after a read or just after the write line falls. The stimulus reaches it by running reads and writes back to back with no idle gap. A bench RAM model keeps its output alive for the full release time after each read and flags any overlap with the drive enable. The same model returns inverted data until the full access time has elapsed, so a capture that is one cycle early corrupts the read-back sweep.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACC,
    ST_RD_END,
    ST_WR_HIZ,
    ST_WR_DAT,
    ST_WR_END
  } ctl_state_e;

  function automatic int ns_to_cyc(input int t_ns, input int clk_ns);
    return (t_ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int RD_CYC  = 14,
  parameter int HIZ_CYC = 6,
  parameter int WD_CYC  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             we,
  input  logic             tmr_zero,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             ready,
  output logic             accept,
  output logic             capture,
  output logic             sel_n,
  output logic             sel,
  output logic             oe_n,
  output logic             rw,
  output logic             drive
);
  ctl_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    capture  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req) begin
        tmr_load = 1'b1;
        if (we) begin
          state_d = ST_WR_HIZ;
          tmr_val = CNT_W'(HIZ_CYC - 1);
        end else begin
          state_d = ST_RD_ACC;
          tmr_val = CNT_W'(RD_CYC - 1);
        end
      end
      ST_RD_ACC: if (tmr_zero) begin
        capture = 1'b1;
        state_d = ST_RD_END;
      end
      ST_RD_END: state_d = ST_IDLE;
      ST_WR_HIZ: if (tmr_zero) begin
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(WD_CYC - 1);
        state_d  = ST_WR_DAT;
      end
      ST_WR_DAT: if (tmr_zero) state_d = ST_WR_END;
      ST_WR_END: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  assign ready  = (state_q == ST_IDLE);
  assign accept = req && ready;

  // Pin stage: every RAM control is a flop loaded from the next state.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sel_n   <= 1'b1;
      sel     <= 1'b0;
      oe_n    <= 1'b1;
      rw      <= 1'b1;
      drive   <= 1'b0;
    end else begin
      state_q <= state_d;
      sel_n   <= !(state_d inside {ST_RD_ACC, ST_WR_HIZ, ST_WR_DAT});
      sel     <=  (state_d inside {ST_RD_ACC, ST_WR_HIZ, ST_WR_DAT});
      oe_n    <= !(state_d == ST_RD_ACC);
      rw      <= !(state_d inside {ST_WR_HIZ, ST_WR_DAT});
      drive   <=  (state_d inside {ST_WR_DAT, ST_WR_END});
    end
  end
endmodule

// File: rtl/asram_datapath.sv
module asram_datapath #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              capture,
  input  logic [DATA_W-1:0] dq_i,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] dq_o,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr    <= '0;
      dq_o        <= '0;
      rdata       <= '0;
      rdata_valid <= 1'b0;
    end else begin
      if (accept)       mem_addr <= addr;
      if (accept && we) dq_o     <= wdata;
      if (capture)      rdata    <= dq_i;
      rdata_valid <= capture;
    end
  end
endmodule

// File: rtl/asram_ctl.sv
module asram_ctl
  import asram_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int DATA_W    = 8,
  parameter int CLK_NS    = 5,
  parameter int T_RC_NS   = 70,
  parameter int T_AA_NS   = 70,
  parameter int T_OE_NS   = 35,
  parameter int T_WC_NS   = 70,
  parameter int T_WP_NS   = 50,
  parameter int T_CW_NS   = 60,
  parameter int T_DS_NS   = 30,
  parameter int T_WHZ_NS  = 25,
  parameter int CNT_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ready,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_oe_n,
  output logic              mem_rw,
  output logic [DATA_W-1:0] mem_dq_o,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              mem_dq_oe
);
  localparam int RD_CYC  = imax(imax(ns_to_cyc(T_RC_NS, CLK_NS), ns_to_cyc(T_AA_NS, CLK_NS)),
                                ns_to_cyc(T_OE_NS, CLK_NS));
  localparam int HIZ_CYC = ns_to_cyc(T_WHZ_NS, CLK_NS) + 1;
  localparam int WD_CYC  = imax(imax(imax(ns_to_cyc(T_DS_NS, CLK_NS),
                                          ns_to_cyc(T_WP_NS, CLK_NS) - HIZ_CYC),
                                     imax(ns_to_cyc(T_CW_NS, CLK_NS) - HIZ_CYC,
                                          ns_to_cyc(T_WC_NS, CLK_NS) - HIZ_CYC - 1)), 1);

  logic             tmr_load, tmr_zero, accept, capture;
  logic [CNT_W-1:0] tmr_val;

  asram_timer #(.CNT_W(CNT_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  asram_seq #(.CNT_W(CNT_W), .RD_CYC(RD_CYC), .HIZ_CYC(HIZ_CYC), .WD_CYC(WD_CYC)) seq_i (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .tmr_zero(tmr_zero),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .ready(ready), .accept(accept),
    .capture(capture), .sel_n(mem_sel_n), .sel(mem_sel), .oe_n(mem_oe_n),
    .rw(mem_rw), .drive(mem_dq_oe)
  );

  asram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .accept(accept), .we(we), .addr(addr), .wdata(wdata),
    .capture(capture), .dq_i(mem_dq_i), .mem_addr(mem_addr), .dq_o(mem_dq_o),
    .rdata(rdata), .rdata_valid(rdata_valid)
  );
endmodule

// File: rtl/asram_ctl_chk.sv
module asram_ctl_chk #(
  parameter int ADDR_W  = 17,
  parameter int HIZ_CYC = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ready,
  input logic              rdata_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_sel_n,
  input logic              mem_sel,
  input logic              mem_oe_n,
  input logic              mem_rw,
  input logic              mem_dq_oe
);
  logic [7:0] rwlow_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              rwlow_q <= '0;
    else if (mem_rw)         rwlow_q <= '0;
    else if (rwlow_q != '1)  rwlow_q <= rwlow_q + 1'b1;
  end

  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (mem_sel_n && !mem_sel && mem_oe_n && mem_rw && !mem_dq_oe)); // R1
  AST_SEL_OPPOSITE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_sel_n != mem_sel); // R3
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_sel && $past(mem_sel)) |-> $stable(mem_addr)); // R3
  AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_valid |=> !rdata_valid); // R4
  AST_DRIVE_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (!mem_rw && rwlow_q >= 8'(HIZ_CYC))); // R6
  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (mem_oe_n && (!mem_rw || !mem_sel))); // R7
  AST_OE_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> mem_rw); // R10
endmodule

bind asram_ctl asram_ctl_chk #(.ADDR_W(ADDR_W), .HIZ_CYC(HIZ_CYC)) chk_i (
  .clk(clk), .rst_n(rst_n), .ready(ready), .rdata_valid(rdata_valid),
  .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel),
  .mem_oe_n(mem_oe_n), .mem_rw(mem_rw), .mem_dq_oe(mem_dq_oe)
);

// File: tb/asram_ctl_tb_top.sv
module asram_ctl_tb_top;
  localparam int CLK_NS = 5;
  function automatic int cy(input int t);
    return (t + CLK_NS - 1) / CLK_NS;
  endfunction
  localparam int RD_MIN  = 14;                 // ceil(70/5)
  localparam int HIZ     = cy(25) + 1;         // 6
  localparam int WHZ     = cy(25);             // 5
  localparam int WD      = 7;                  // max(6, 10-6, 12-6, 14-1-6)
  localparam int RV_AT   = RD_MIN + 1;         // 15
  localparam int RRDY_AT = RD_MIN + 2;         // 16
  localparam int WRDY_AT = HIZ + WD + 2;       // 15

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [16:0] addr = '0;
  logic [7:0]  wdata = '0, rdata, ram_q = '0, mem_dq_o;
  logic ready, rdata_valid, mem_sel_n, mem_sel, mem_oe_n, mem_rw, mem_dq_oe;
  logic [16:0] mem_addr;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  asram_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .ready(ready), .rdata(rdata), .rdata_valid(rdata_valid), .mem_addr(mem_addr),
    .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_oe_n(mem_oe_n), .mem_rw(mem_rw),
    .mem_dq_o(mem_dq_o), .mem_dq_i(ram_q), .mem_dq_oe(mem_dq_oe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // RAM model, evaluated between edges
  logic [7:0] mem_m [int];
  int rd_cnt = 0, tail = 0, wr_len = 0, wd_len = 0, wr_addr = 0;
  logic [16:0] rd_addr = '0;
  logic [7:0]  wr_data = '0;

  function automatic logic [7:0] mem_rd(input int a);
    return mem_m.exists(a) ? mem_m[a] : 8'h00;
  endfunction

  always @(negedge clk) if (rst_n) begin
    bit sel, ram_on;
    sel    = !mem_sel_n && mem_sel;
    ram_on = sel && mem_rw && !mem_oe_n;
    if (mem_dq_oe && (ram_on || tail != 0))
      chk(1'b0, "R7 contention", 1, 0);
    if (mem_sel_n == mem_sel) chk(1'b0, "R3 select pair", mem_sel, !mem_sel_n);
    if (!mem_rw && !mem_oe_n) chk(1'b0, "R10 oe during write", mem_oe_n, 1);
    tail = ram_on ? WHZ : (tail > 0 ? tail - 1 : 0);
    if (ram_on && rd_cnt > 0 && mem_addr == rd_addr) rd_cnt++;
    else rd_cnt = ram_on ? 1 : 0;
    rd_addr = mem_addr;
    ram_q = (rd_cnt >= RD_MIN) ? mem_rd(int'(mem_addr)) : ~mem_rd(int'(mem_addr));
    if (sel && !mem_rw) begin
      wr_len++;
      wr_addr = int'(mem_addr);
      if (mem_dq_oe) begin
        if (wd_len > 0 && mem_dq_o == wr_data) wd_len++;
        else begin wd_len = 1; wr_data = mem_dq_o; end
      end
    end else if (wr_len > 0) begin
      chk(wr_len == HIZ + WD, "R5 rw low length", wr_len, HIZ + WD);
      chk(wr_len >= cy(50) && wr_len >= cy(60), "R8 pulse width", wr_len, cy(60));
      chk(wd_len >= cy(30), "R8 data setup", wd_len, cy(30));
      chk(!mem_sel && mem_rw, "R5 release together", {mem_sel, mem_rw}, 1);
      mem_m[wr_addr] = wr_data;
      wr_len = 0;
      wd_len = 0;
    end
  end

  task automatic op(input bit w, input logic [16:0] a, input logic [7:0] d, input bit gap);
    int k, vk;
    logic [7:0] got;
    vk = -1; got = '0;
    @(negedge clk);
    while (!ready) @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(posedge clk);
    #1;
    req = 1'b0; addr = ~a; wdata = ~d; we = ~w;   // R2: post-accept changes ignored
    k = 0;
    do begin
      @(negedge clk);
      k++;
      if (rdata_valid) begin
        chk(vk < 0, "R4 single valid pulse", k, vk);
        vk = k; got = rdata;
      end
      if (!ready && (mem_sel ? 1'b0 : 1'b0)) ;
    end while (!ready && k < 100);
    chk(ready && !mem_sel && mem_oe_n && mem_rw && !mem_dq_oe && !rdata_valid,
        "R1 idle pins after op", {mem_sel, mem_oe_n, mem_rw, mem_dq_oe}, 4'b0110);
    if (w) begin
      chk(k == WRDY_AT, "R5 write ready cycle", k, WRDY_AT);
      chk(vk < 0, "R2 no valid on write", vk, -1);
    end else begin
      chk(k == RRDY_AT, "R4 read ready cycle", k, RRDY_AT);
      chk(vk == RV_AT, "R4 valid cycle", vk, RV_AT);
      chk(got == d, "R9 read data", got, d);
    end
    if (gap) repeat (2) @(negedge clk);
  endtask

  function automatic logic [7:0] pat(input logic [16:0] a, input int s);
    return a[7:0] ^ {a[15:8]} ^ {7'd0, a[16]} ^ 8'(s * 37 + 8'h5A);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk(mem_sel_n && !mem_sel && mem_oe_n && mem_rw && !mem_dq_oe && !rdata_valid,
        "R1 reset pins", {mem_sel_n, mem_sel, mem_oe_n, mem_rw, mem_dq_oe}, 5'b10110);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready, "R1 ready after reset", ready, 1);
    // sweep: edge addresses, walking ones, and a dense low block
    for (int s = 0; s < 2; s++) begin
      op(1'b1, 17'h00000, pat(17'h00000, s), s == 0);
      op(1'b1, 17'h1FFFF, pat(17'h1FFFF, s), s == 0);
      for (int b = 0; b < 17; b++) op(1'b1, 17'(1) << b, pat(17'(1) << b, s), 1'b0);
      for (int i = 2; i < 34; i++) op(1'b1, 17'(i * 3), pat(17'(i * 3), s), s == 1);
      op(1'b0, 17'h00000, pat(17'h00000, s), 1'b0);
      op(1'b0, 17'h1FFFF, pat(17'h1FFFF, s), s == 1);
      for (int b = 0; b < 17; b++) op(1'b0, 17'(1) << b, pat(17'(1) << b, s), 1'b0);
      for (int i = 2; i < 34; i++) op(1'b0, 17'(i * 3), pat(17'(i * 3), s), s == 0);
    end
    // read-write-read interleave at one address without idle gaps
    for (int i = 0; i < 8; i++) begin
      op(1'b1, 17'h0AAAA, 8'(i * 29 + 1), 1'b0);
      op(1'b0, 17'h0AAAA, 8'(i * 29 + 1), 1'b0);
    end
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog R2", 0, 1);
    finish_run();
  end
endmodule